// File: doc/BRIEF.md
# Deep-Stop Wake and Reset Sequencer

This controller brings a chip's main power domain out of a deep stop state and starts it after any reset. Software parks the block in the stop state with a one-cycle request. In that state the main supply is off and the domain is held in reset. Three events end the stop: an active-low external reset pin, a low-voltage reset and an interrupt request. Every wake takes the same path. The supply is switched on first and allowed to settle. The domain is then held in reset for a programmable minimum time, and for longer while the pin or the low-voltage source is still asserted. An interrupt wake therefore also starts the main domain from a clean reset.

When the reset is released, the active-low boot-select pin is captured. Low selects single-boot start and high selects normal start. A programmable CPU wait interval follows, and then a one-cycle CPU start strobe. While the boot pin is being sampled, a pull-up enable is driven to the pad. Three wake-cause flags sit in the always-on part of the block. Only the cold power-on reset clears them, so they survive every main-domain reset. Software clears a flag by writing a one to it.

The pin, low-voltage and boot inputs pass through two-flop synchronizers before the controller uses them. The interrupt request is taken as already synchronous.

Top module: `stopwake_seq`

## Requirements
- R1: While cold reset `rstN` is low: supplyEn=1, mainRstN=0, cpuStart=0, bootPullUp=1, deepStop=0 and causeFlags=0.
- R2: In run mode, stopReq high at a clock edge enters the stop state at that edge. In that state supplyEn=0, mainRstN=0, bootPullUp=0 and deepStop=1.
- R3: In the stop state, each of these causes a wake: reset pin low, low-voltage reset high, irqReq high. An interrupt sampled at an edge drives supplyEn high from that edge.
- R4: After a wake, mainRstN stays low for exactly max(settleCyc,1)+max(initCyc,1) cycles, counted from the supplyEn rise. This holds when the reset sources are already released.
- R5: mainRstN is low in the cycle after any cycle in which the synchronized reset pin is low or the synchronized low-voltage reset is high. The initialization count does not shorten this.
- R6: After mainRstN rises, cpuStart pulses high for exactly one cycle, max(waitCyc,1) cycles later.
- R7: singleBoot takes the inverse of the synchronized boot pin at the edge where mainRstN rises (pin low gives 1). It holds that value until the next rise of mainRstN.
- R8: bootPullUp is high only while the supply is on and the main reset is held. It is low in the stop state and whenever mainRstN is high.
- R9: causeFlags bit 0 records a reset-pin wake, bit 1 a low-voltage wake and bit 2 an interrupt wake. Each bit is set only at a wake from the stop state. A bit stays set until a one is written to the same bit of flagClr. A set and a clear in the same cycle leave the bit set.
- R10: causeFlags keep their values through every main-domain reset. These include wake resets and resets from the pin while running.
- R11: Outside the stop state, the reset pin or the low-voltage reset re-asserts the main reset three edges after the pin changes, with the supply kept on. The full initialization and wait sequence then repeats.
- R12: stopReq has no effect outside run mode, for example during the CPU wait interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rstN | input | 1 | Cold power-on reset, active low |
| rstPinN | input | 1 | External reset pin, active low, asynchronous |
| lvdRst | input | 1 | Low-voltage reset request, active high, asynchronous |
| irqReq | input | 1 | Wake interrupt request, synchronous |
| bootPinN | input | 1 | Boot-select pin, low selects single boot, asynchronous |
| stopReq | input | 1 | Request to enter the deep stop state |
| settleCyc | input | CNT_W | Supply-settle time in cycles (0 acts as 1) |
| initCyc | input | CNT_W | Minimum main-reset hold time in cycles (0 acts as 1) |
| waitCyc | input | CNT_W | Cycles from reset release to CPU start (0 acts as 1) |
| flagClr | input | 3 | Write-one-to-clear strobes for causeFlags |
| supplyEn | output | 1 | Main-domain supply enable |
| mainRstN | output | 1 | Main-domain reset, active low |
| cpuStart | output | 1 | One-cycle CPU start strobe |
| singleBoot | output | 1 | Captured boot mode, 1 = single boot |
| bootPullUp | output | 1 | Pull-up enable for the boot-select pin |
| deepStop | output | 1 | High while in the deep stop state |
| causeFlags | output | 3 | Sticky wake-cause flags |

## Verification
The bench wakes the block by interrupt, by low-voltage reset alone, and by pin and low-voltage reset together. Each wake has its own interval settings, including all-zero settings. A scoreboard times each wake from the supply turning on to the reset release and the CPU start. A counter off by one, or one that treats zero as a long count, shows up as a wrong interval. The bench holds the reset pin low well past the initialization time while the block is running. A design that released on the count alone would raise the main reset too early. Flags are cleared in the same cycle as a new wake, which catches a design that lets the clear win. The flags are read after a running-mode reset, which catches a design that clears them with the main domain. A stop request is issued during the CPU wait. A design that accepts it outside run mode would shut the supply off before the CPU starts. The boot pin is toggled after capture, which catches a boot mode that follows the pin instead of holding it.

// File: rtl/stopwake_pkg.sv
package stopwake_pkg;

  // Controller states; outputs are decoded from these.
  typedef enum logic [2:0] {
    ST_SETTLE = 3'd0,  // supply on, waiting for it to settle, domain in reset
    ST_INIT   = 3'd1,  // domain in reset, minimum hold and source release
    ST_WAIT   = 3'd2,  // reset released, CPU wait interval
    ST_GO     = 3'd3,  // one-cycle CPU start
    ST_RUN    = 3'd4,  // normal run mode
    ST_STOP   = 3'd5   // deep stop, supply off
  } seqState_t;

  localparam int CAUSE_N   = 3;
  localparam int CAUSE_PIN = 0;
  localparam int CAUSE_LVD = 1;
  localparam int CAUSE_IRQ = 2;

  localparam int TIMER_N      = 3;
  localparam int TIMER_SETTLE = 0;
  localparam int TIMER_INIT   = 1;
  localparam int TIMER_WAIT   = 2;

  // Strobes from control to datapath.
  typedef struct packed {
    logic [TIMER_N-1:0] timerRun;    // one per interval counter
    logic               bootCapture; // latch boot mode this edge
    logic [CAUSE_N-1:0] causeSet;    // wake causes seen this edge
  } ctlStrobe_t;

endpackage

// File: rtl/stopwake_sync.sv
module stopwake_sync #(
  parameter int           W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage1;
  logic [W-1:0] stage2;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1 <= RST_VAL;
      stage2 <= RST_VAL;
    end else begin
      stage1 <= d;
      stage2 <= stage1;
    end
  end

  assign q = stage2;

endmodule

// File: rtl/stopwake_timer.sv
module stopwake_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             run,
  input  logic [CNT_W-1:0] limit,
  output logic             done
);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W:0]   cntInc;

  assign cntInc = {1'b0, cnt} + {{CNT_W{1'b0}}, 1'b1};
  // Done in the last cycle of a max(limit,1)-cycle interval.
  assign done   = cntInc >= {1'b0, limit};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (!run) begin
      cnt <= '0;
    end else if (!done) begin
      cnt <= cntInc[CNT_W-1:0];
    end
  end

endmodule

// File: rtl/stopwake_ctrl.sv
module stopwake_ctrl
  import stopwake_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       stopReq,
  input  logic       irqReq,
  input  logic       pinLow,
  input  logic       lvdHigh,
  input  logic       rstActive,
  input  logic       settleDone,
  input  logic       initDone,
  input  logic       waitDone,
  output ctlStrobe_t strobe,
  output logic       supplyEn,
  output logic       mainRstN,
  output logic       cpuStart,
  output logic       bootPullUp,
  output logic       deepStop
);

  seqState_t state;
  seqState_t stateNext;
  logic      wakeEvent;

  assign wakeEvent = rstActive | irqReq;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_SETTLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext            = state;
    strobe               = '0;
    strobe.timerRun[TIMER_SETTLE] = (state == ST_SETTLE);
    strobe.timerRun[TIMER_INIT]   = (state == ST_INIT);
    strobe.timerRun[TIMER_WAIT]   = (state == ST_WAIT);
    case (state)
      ST_SETTLE: begin
        if (settleDone) stateNext = ST_INIT;
      end
      ST_INIT: begin
        if (initDone && !rstActive) begin
          stateNext          = ST_WAIT;
          strobe.bootCapture = 1'b1;
        end
      end
      ST_WAIT: begin
        if (rstActive)     stateNext = ST_INIT;
        else if (waitDone) stateNext = ST_GO;
      end
      ST_GO: begin
        stateNext = rstActive ? ST_INIT : ST_RUN;
      end
      ST_RUN: begin
        if (rstActive)    stateNext = ST_INIT;
        else if (stopReq) stateNext = ST_STOP;
      end
      ST_STOP: begin
        if (wakeEvent) begin
          stateNext                  = ST_SETTLE;
          strobe.causeSet[CAUSE_PIN] = pinLow;
          strobe.causeSet[CAUSE_LVD] = lvdHigh;
          strobe.causeSet[CAUSE_IRQ] = irqReq;
        end
      end
      default: stateNext = ST_SETTLE;
    endcase
  end

  assign supplyEn   = (state != ST_STOP);
  assign mainRstN   = (state == ST_WAIT) | (state == ST_GO) | (state == ST_RUN);
  assign cpuStart   = (state == ST_GO);
  assign bootPullUp = (state == ST_SETTLE) | (state == ST_INIT);
  assign deepStop   = (state == ST_STOP);

endmodule

// File: rtl/stopwake_dp.sv
module stopwake_dp
  import stopwake_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctlStrobe_t         strobe,
  input  logic [CNT_W-1:0]   settleCyc,
  input  logic [CNT_W-1:0]   initCyc,
  input  logic [CNT_W-1:0]   waitCyc,
  input  logic               bootLow,
  input  logic [CAUSE_N-1:0] flagClr,
  output logic               settleDone,
  output logic               initDone,
  output logic               waitDone,
  output logic               singleBoot,
  output logic [CAUSE_N-1:0] causeFlags
);

  logic [TIMER_N-1:0][CNT_W-1:0] timerLimit;
  logic [TIMER_N-1:0]            timerDone;

  assign timerLimit[TIMER_SETTLE] = settleCyc;
  assign timerLimit[TIMER_INIT]   = initCyc;
  assign timerLimit[TIMER_WAIT]   = waitCyc;

  // One independent counter per interval.
  for (genvar g = 0; g < TIMER_N; g++) begin : g_timer
    stopwake_timer #(.CNT_W(CNT_W)) timer_i (
      .clk   (clk),
      .rstN  (rstN),
      .run   (strobe.timerRun[g]),
      .limit (timerLimit[g]),
      .done  (timerDone[g])
    );
  end

  assign settleDone = timerDone[TIMER_SETTLE];
  assign initDone   = timerDone[TIMER_INIT];
  assign waitDone   = timerDone[TIMER_WAIT];

  // Always-on state: cleared by cold reset only.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      causeFlags <= '0;
      singleBoot <= 1'b0;
    end else begin
      causeFlags <= (causeFlags & ~flagClr) | strobe.causeSet;
      if (strobe.bootCapture) singleBoot <= bootLow;
    end
  end

endmodule

// File: rtl/stopwake_seq.sv
module stopwake_seq
  import stopwake_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               rstPinN,
  input  logic               lvdRst,
  input  logic               irqReq,
  input  logic               bootPinN,
  input  logic               stopReq,
  input  logic [CNT_W-1:0]   settleCyc,
  input  logic [CNT_W-1:0]   initCyc,
  input  logic [CNT_W-1:0]   waitCyc,
  input  logic [CAUSE_N-1:0] flagClr,
  output logic               supplyEn,
  output logic               mainRstN,
  output logic               cpuStart,
  output logic               singleBoot,
  output logic               bootPullUp,
  output logic               deepStop,
  output logic [CAUSE_N-1:0] causeFlags
);

  localparam int SYNC_W = 3;
  // Synchronizer reset values: pin asserted, low-voltage asserted, boot high.
  localparam logic [SYNC_W-1:0] SYNC_RST = 3'b110;

  logic [SYNC_W-1:0] syncOut;
  logic              pinLow;
  logic              lvdHigh;
  logic              bootLow;
  logic              rstActive;
  ctlStrobe_t        strobe;
  logic              settleDone;
  logic              initDone;
  logic              waitDone;

  stopwake_sync #(.W(SYNC_W), .RST_VAL(SYNC_RST)) inSync_i (
    .clk  (clk),
    .rstN (rstN),
    .d    ({bootPinN, lvdRst, rstPinN}),
    .q    (syncOut)
  );

  assign pinLow    = ~syncOut[0];
  assign lvdHigh   = syncOut[1];
  assign bootLow   = ~syncOut[2];
  assign rstActive = pinLow | lvdHigh;

  stopwake_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .stopReq    (stopReq),
    .irqReq     (irqReq),
    .pinLow     (pinLow),
    .lvdHigh    (lvdHigh),
    .rstActive  (rstActive),
    .settleDone (settleDone),
    .initDone   (initDone),
    .waitDone   (waitDone),
    .strobe     (strobe),
    .supplyEn   (supplyEn),
    .mainRstN   (mainRstN),
    .cpuStart   (cpuStart),
    .bootPullUp (bootPullUp),
    .deepStop   (deepStop)
  );

  stopwake_dp #(.CNT_W(CNT_W)) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .settleCyc  (settleCyc),
    .initCyc    (initCyc),
    .waitCyc    (waitCyc),
    .bootLow    (bootLow),
    .flagClr    (flagClr),
    .settleDone (settleDone),
    .initDone   (initDone),
    .waitDone   (waitDone),
    .singleBoot (singleBoot),
    .causeFlags (causeFlags)
  );

endmodule

// File: rtl/stopwake_chk.sv
module stopwake_chk (
  input logic       clk,
  input logic       rstN,
  input logic       rstActive,
  input logic [2:0] flagClr,
  input logic       supplyEn,
  input logic       mainRstN,
  input logic       cpuStart,
  input logic       singleBoot,
  input logic       bootPullUp,
  input logic       deepStop,
  input logic [2:0] causeFlags
);

  a_r2_stop_dark: assert property (@(posedge clk) disable iff (!rstN)
    deepStop |-> (!supplyEn && !mainRstN && !bootPullUp));

  a_r3_wake_powers: assert property (@(posedge clk) disable iff (!rstN)
    $fell(deepStop) |-> (supplyEn && !mainRstN));

  a_r4_release_powered: assert property (@(posedge clk) disable iff (!rstN)
    $rose(mainRstN) |-> (supplyEn && $past(supplyEn)));

  a_r5_source_holds: assert property (@(posedge clk) disable iff (!rstN)
    rstActive |=> !mainRstN);

  a_r6_one_shot: assert property (@(posedge clk) disable iff (!rstN)
    cpuStart |=> !cpuStart);

  a_r6_after_release: assert property (@(posedge clk) disable iff (!rstN)
    cpuStart |-> (mainRstN && $past(mainRstN)));

  a_r7_boot_at_release: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(singleBoot) |-> $rose(mainRstN));

  a_r8_pullup_in_reset: assert property (@(posedge clk) disable iff (!rstN)
    mainRstN |-> !bootPullUp);

  a_r9_sticky: assert property (@(posedge clk) disable iff (!rstN)
    ((causeFlags & ~flagClr) != 3'b000) |=>
      ((causeFlags & $past(causeFlags & ~flagClr)) == $past(causeFlags & ~flagClr)));

  a_r9_set_on_wake: assert property (@(posedge clk) disable iff (!rstN)
    ((causeFlags & ~$past(causeFlags)) != 3'b000) |-> $past(deepStop));

endmodule

bind stopwake_seq stopwake_chk chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .rstActive  (rstActive),
  .flagClr    (flagClr),
  .supplyEn   (supplyEn),
  .mainRstN   (mainRstN),
  .cpuStart   (cpuStart),
  .singleBoot (singleBoot),
  .bootPullUp (bootPullUp),
  .deepStop   (deepStop),
  .causeFlags (causeFlags)
);

// File: tb/stopwake_seq_tb.sv
module stopwake_seq_tb_top;

  localparam int CLK_PERIOD   = 10;
  localparam int CNT_W        = 16;
  localparam int WATCHDOG_CYC = 20000;
  localparam int WAIT_LIMIT   = 1000;

  logic             clk = 1'b0;
  logic             rstN;
  logic             rstPinN;
  logic             lvdRst;
  logic             irqReq;
  logic             bootPinN;
  logic             stopReq;
  logic [CNT_W-1:0] settleCyc;
  logic [CNT_W-1:0] initCyc;
  logic [CNT_W-1:0] waitCyc;
  logic [2:0]       flagClr;
  logic             supplyEn;
  logic             mainRstN;
  logic             cpuStart;
  logic             singleBoot;
  logic             bootPullUp;
  logic             deepStop;
  logic [2:0]       causeFlags;

  always #(CLK_PERIOD/2) clk = ~clk;

  stopwake_seq #(.CNT_W(CNT_W)) dut_i (
    .clk(clk), .rstN(rstN), .rstPinN(rstPinN), .lvdRst(lvdRst), .irqReq(irqReq),
    .bootPinN(bootPinN), .stopReq(stopReq), .settleCyc(settleCyc), .initCyc(initCyc),
    .waitCyc(waitCyc), .flagClr(flagClr), .supplyEn(supplyEn), .mainRstN(mainRstN),
    .cpuStart(cpuStart), .singleBoot(singleBoot), .bootPullUp(bootPullUp),
    .deepStop(deepStop), .causeFlags(causeFlags)
  );

  int nChecks = 0;
  int nErrors = 0;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Scoreboard of expected wake sequences.
  typedef struct {
    int   settleInit;
    int   waitLen;
    logic boot;
  } expItem_t;
  expItem_t expQ[$];

  int   cyc = 0;
  int   tSup = 0;
  int   tRel = 0;
  bit   armed = 0;
  logic prevSup = 1'b1;
  logic prevRst = 1'b0;

  // Monitor: times each wake and compares against the queue.
  always @(negedge clk) begin
    expItem_t item;
    cyc++;
    if (rstN) begin
      if (supplyEn && !prevSup) begin
        armed = 1;
        tSup  = cyc;
      end
      if (mainRstN && !prevRst && armed) tRel = cyc;
      if (cpuStart && armed) begin
        if (expQ.size() == 0) begin
          check("R4", "unexpected wake sequence", 1, 0);
        end else begin
          item = expQ.pop_front();
          check("R4", "supply-on to reset release", 32'(tRel - tSup), 32'(item.settleInit));
          check("R6", "reset release to cpu start", 32'(cyc - tRel), 32'(item.waitLen));
          check("R7", "boot mode after wake", {31'b0, singleBoot}, {31'b0, item.boot});
        end
        armed = 0;
      end
    end
    prevSup = supplyEn;
    prevRst = mainRstN;
  end

  task automatic waitCpuStart(input string req);
    for (int i = 0; i < WAIT_LIMIT; i++) begin
      @(negedge clk);
      if (cpuStart) return;
    end
    check(req, "cpu start timeout", 0, 1);
  endtask

  task automatic waitRelease(input string req);
    for (int i = 0; i < WAIT_LIMIT; i++) begin
      @(negedge clk);
      if (mainRstN) return;
    end
    check(req, "reset release timeout", 0, 1);
  endtask

  task automatic enterStop();
    @(negedge clk);
    stopReq = 1'b1;
    @(negedge clk);
    stopReq = 1'b0;
  endtask

  task automatic pushExp(input int s, input int i, input int w, input logic boot);
    expItem_t it;
    it.settleInit = (s < 1 ? 1 : s) + (i < 1 ? 1 : i);
    it.waitLen    = (w < 1 ? 1 : w);
    it.boot       = boot;
    expQ.push_back(it);
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG_CYC) @(posedge clk);
    nErrors++;
    $display("FAIL watchdog: actual hung expected finished");
    finishRun();
  end

  initial begin
    rstN = 1'b0; rstPinN = 1'b1; lvdRst = 1'b0; irqReq = 1'b0; bootPinN = 1'b1;
    stopReq = 1'b0; flagClr = 3'b000;
    settleCyc = 16'd4; initCyc = 16'd6; waitCyc = 16'd3;
    repeat (3) @(negedge clk);
    // R1: cold reset state
    check("R1", "supplyEn", {31'b0, supplyEn}, 1);
    check("R1", "mainRstN", {31'b0, mainRstN}, 0);
    check("R1", "cpuStart", {31'b0, cpuStart}, 0);
    check("R1", "bootPullUp", {31'b0, bootPullUp}, 1);
    check("R1", "deepStop", {31'b0, deepStop}, 0);
    check("R1", "causeFlags", {29'b0, causeFlags}, 0);
    rstN = 1'b1;
    waitCpuStart("R6");
    check("R7", "cold boot with pin high", {31'b0, singleBoot}, 0);
    check("R8", "pull-up off in run", {31'b0, bootPullUp}, 0);
    @(negedge clk);
    check("R6", "start pulse single cycle", {31'b0, cpuStart}, 0);

    // R2: enter stop
    enterStop();
    check("R2", "deepStop", {31'b0, deepStop}, 1);
    check("R2", "supplyEn off", {31'b0, supplyEn}, 0);
    check("R2", "mainRstN low", {31'b0, mainRstN}, 0);
    check("R8", "pull-up off in stop", {31'b0, bootPullUp}, 0);

    // R3: interrupt wake, boot pin low
    bootPinN = 1'b0;
    repeat (3) @(negedge clk);
    pushExp(4, 6, 3, 1'b1);
    irqReq = 1'b1;
    @(negedge clk);
    irqReq = 1'b0;
    check("R3", "supply on after irq", {31'b0, supplyEn}, 1);
    check("R8", "pull-up on during wake reset", {31'b0, bootPullUp}, 1);
    waitCpuStart("R4");
    check("R9", "irq cause flag", {29'b0, causeFlags}, 3'b100);
    // R7: boot mode holds while the pin changes in run
    bootPinN = 1'b1;
    repeat (5) @(negedge clk);
    check("R7", "boot mode held after pin change", {31'b0, singleBoot}, 1);
    // R9: write-one-to-clear
    flagClr = 3'b100;
    @(negedge clk);
    flagClr = 3'b000;
    check("R9", "flag cleared", {29'b0, causeFlags}, 0);

    // R3: low-voltage wake with new intervals
    settleCyc = 16'd2; initCyc = 16'd12; waitCyc = 16'd5;
    enterStop();
    pushExp(2, 12, 5, 1'b0);
    lvdRst = 1'b1;
    repeat (2) @(negedge clk);
    lvdRst = 1'b0;
    waitCpuStart("R4");
    check("R9", "lvd cause flag", {29'b0, causeFlags}, 3'b010);

    // R11 and R5: reset pin while running
    @(negedge clk);
    rstPinN = 1'b0;
    repeat (3) @(negedge clk);
    check("R11", "main reset re-asserted", {31'b0, mainRstN}, 0);
    check("R11", "supply stays on", {31'b0, supplyEn}, 1);
    repeat (27) @(negedge clk);
    check("R5", "reset held while pin low", {31'b0, mainRstN}, 0);
    rstPinN = 1'b1;
    waitRelease("R11");
    // R12: stop request during CPU wait is ignored
    stopReq = 1'b1;
    @(negedge clk);
    stopReq = 1'b0;
    check("R12", "no stop during wait", {31'b0, deepStop}, 0);
    waitCpuStart("R11");
    @(negedge clk);
    check("R12", "still powered after start", {31'b0, supplyEn}, 1);
    check("R10", "flags kept through reset", {29'b0, causeFlags}, 3'b010);

    // R9: combined pin and low-voltage wake
    flagClr = 3'b111;
    @(negedge clk);
    flagClr = 3'b000;
    check("R9", "all flags cleared", {29'b0, causeFlags}, 0);
    bootPinN = 1'b0;
    enterStop();
    pushExp(2, 12, 5, 1'b1);
    rstPinN = 1'b0;
    lvdRst  = 1'b1;
    repeat (3) @(negedge clk);
    rstPinN = 1'b1;
    lvdRst  = 1'b0;
    waitCpuStart("R4");
    check("R9", "pin and lvd flags", {29'b0, causeFlags}, 3'b011);

    // R4/R6 boundary: zero intervals act as one cycle; R9 set beats clear
    settleCyc = 16'd0; initCyc = 16'd0; waitCyc = 16'd0;
    bootPinN = 1'b1;
    enterStop();
    repeat (2) @(negedge clk);
    pushExp(0, 0, 0, 1'b0);
    irqReq  = 1'b1;
    flagClr = 3'b111;
    @(negedge clk);
    irqReq  = 1'b0;
    flagClr = 3'b000;
    check("R9", "set wins over clear", {29'b0, causeFlags}, 3'b100);
    waitCpuStart("R4");
    repeat (2) @(negedge clk);
    check("R4", "scoreboard drained", 32'(expQ.size()), 0);
    finishRun();
  end

endmodule